// File: doc/BRIEF.md
# PCI Base Address Window Decoder

This block holds six base address registers for a PCI function and decodes an incoming address against all six windows at once. Each window has a base that software programs through a small config-write port and a size fixed at build time by a parameter. The block reports whether the address falls in any window, which window it falls in, and how far into that window it lies. When windows overlap, the lowest-numbered window wins.

Each config write carries a byte offset and a 32-bit value. Bit 0 of the value selects the window type: 1 for I/O space, 0 for memory space. For an I/O window, the two type bits at the bottom are cleared to form the base. For a memory window, the bottom four bits are cleared. The type of each window is brought out on a status vector.

The lookup path is purely combinational, so a result is valid in the same cycle as its address. There is no handshake on it: the block never stalls the lookup, and a new address can be presented in every cycle.

Top module: `bar_decoder`

## Requirements
- R1: An address `a` hits window i exactly when base_i <= a < base_i + size_i. The lower bound is inclusive and the upper bound is exclusive. On a hit, `hit` is 1 and `hit_idx` is the window number (0..5).
- R2: When several windows contain the address, `hit_idx` is the lowest-numbered of them.
- R3: On a hit, `hit_off` equals the address minus the base of the reported window.
- R4: When no window contains the address, `hit` is 0, `hit_idx` is 3'b111 and `hit_off` is 0.
- R5: A window whose size parameter is 0 never hits, whatever its base. With the default sizes this is window 3.
- R6: A config write with data bit 0 = 1 marks the window as I/O (`bar_is_io[i]` = 1) and stores the data with bits [1:0] cleared as the base. A write with bit 0 = 0 marks it as memory (`bar_is_io[i]` = 0) and stores the data with bits [3:0] cleared.
- R7: Window i is written at byte offset 0x10 + 4*i. The low two offset bits are ignored, so offsets 0x10..0x27 map to windows 0..5. A write to any offset below 0x10 or above 0x27 changes no window.
- R8: A synchronous reset clears every base to 0 and every type to memory. With the default sizes, address 0 then hits window 0.
- R9: A window that ends exactly at 2^32 does not wrap around. Address 0xFFFFFFFF hits a window with base 0xF0000000 and size 0x10000000.
- R10: A config write takes effect at the rising clock edge on which `cfg_wr_en` is high. Before that edge, the lookup still uses the old base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_en | input | 1 | Config write strobe |
| cfg_off | input | 8 | Config byte offset of the write |
| cfg_wdata | input | 32 | Config write data, bit 0 selects I/O type |
| lookup_addr | input | 32 | Address to decode |
| hit | output | 1 | Address falls inside some window |
| hit_idx | output | 3 | Winning window number, 3'b111 on a miss |
| hit_off | output | 32 | Address minus winning base, 0 on a miss |
| bar_is_io | output | 6 | Per-window type, 1 = I/O space |

## Verification
The bench probes the addresses at base-1, base, base+size-1 and base+size of each window. An off-by-one bound would misreport exactly one of those four points.

Overlapping windows are set up on purpose. A priority encoder that picks the highest match, or ORs the offsets together, then returns the wrong index or offset.

A window is placed at the top of the address space, and its last address must hit. A 32-bit end sum would wrap to zero and make that window miss everywhere.

Config writes go to the offsets just outside the window block and to the unaligned offsets inside it. I/O-type and memory-type data are both used, so wrong index arithmetic or the wrong type mask would corrupt the base that later probes read.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;

  typedef enum logic {
    WIN_MEM = 1'b0,
    WIN_IO  = 1'b1
  } win_kind_e;

  // Low-bit mask of a given width, used to clear type bits from a base.
  function automatic logic [31:0] low_mask(input int bits);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < 32; b++) begin
      if (b < bits) m[b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/bar_cfg_regs.sv
module bar_cfg_regs
  import bar_dec_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter int ADDR_W   = 32,
  parameter int CFG_W    = 8,
  parameter int BAR0_OFF = 16,
  parameter int IO_LOW   = 2,
  parameter int MEM_LOW  = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [CFG_W-1:0]               wr_off,
  input  logic [ADDR_W-1:0]              wr_data,
  output logic [NUM_BARS-1:0][ADDR_W-1:0] base_o,
  output logic [NUM_BARS-1:0]            io_o
);

  localparam int SPAN = NUM_BARS * 4;
  localparam logic [CFG_W-1:0] OFF_LO = CFG_W'(BAR0_OFF);
  localparam logic [CFG_W-1:0] OFF_HI = CFG_W'(BAR0_OFF + SPAN);
  localparam logic [ADDR_W-1:0] IO_CLR  = ADDR_W'(low_mask(IO_LOW));
  localparam logic [ADDR_W-1:0] MEM_CLR = ADDR_W'(low_mask(MEM_LOW));

  logic [CFG_W-1:0]  rel_off;
  logic [CFG_W-1:0]  slot;
  logic              in_block;
  win_kind_e         kind;
  logic [ADDR_W-1:0] clean_base;

  // Offset to slot mapping: consecutive 32-bit words from the first window.
  always_comb begin
    rel_off  = wr_off - OFF_LO;
    slot     = rel_off >> 2;
    in_block = (wr_off >= OFF_LO) && (wr_off < OFF_HI);
  end

  // Type bit picks how many low bits are stripped from the base.
  always_comb begin
    kind       = wr_data[0] ? WIN_IO : WIN_MEM;
    clean_base = (kind == WIN_IO) ? (wr_data & ~IO_CLR) : (wr_data & ~MEM_CLR);
  end

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_slot
    logic sel_here;
    assign sel_here = wr_en && in_block && (slot == CFG_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_o[i] <= '0;
        io_o[i]   <= 1'b0;
      end else if (sel_here) begin
        base_o[i] <= clean_base;
        io_o[i]   <= (kind == WIN_IO);
      end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_off >= OFF_LO) && (wr_off < OFF_HI) &&
       (((wr_off - OFF_LO) >> 2) == CFG_W'(i)))
      |=> (io_o[i] == $past(wr_data[0])) &&
          (base_o[i][ADDR_W-1:MEM_LOW] == $past(wr_data[ADDR_W-1:MEM_LOW]))); // R6

    AST_TYPE_BITS_CLEAR: assert property (@(posedge clk) disable iff (rst)
      io_o[i] ? (base_o[i][IO_LOW-1:0] == '0) : (base_o[i][MEM_LOW-1:0] == '0)); // R6
  end

  AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ((wr_off < OFF_LO) || (wr_off >= OFF_HI)))
    |=> ($stable(base_o) && $stable(io_o))); // R7

endmodule

// File: rtl/bar_window.sv
module bar_window #(
  parameter int                ADDR_W = 32,
  parameter logic [ADDR_W-1:0] SIZE   = '0
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              match_o,
  output logic [ADDR_W-1:0] offset_o
);

  assign offset_o = addr_i - base_i;

  if (SIZE == '0) begin : g_empty
    assign match_o = 1'b0;
  end else begin : g_live
    logic [ADDR_W:0] end_x;
    // One extra bit keeps a window that ends at the top of the space from wrapping.
    assign end_x   = {1'b0, base_i} + {1'b0, SIZE};
    assign match_o = (addr_i >= base_i) && ({1'b0, addr_i} < end_x);
  end

endmodule

// File: rtl/bar_prio_sel.sv
module bar_prio_sel #(
  parameter int NUM_BARS = 6,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 3
) (
  input  logic [NUM_BARS-1:0]             match_i,
  input  logic [NUM_BARS-1:0][ADDR_W-1:0] offs_i,
  output logic                            hit_o,
  output logic [IDX_W-1:0]                idx_o,
  output logic [ADDR_W-1:0]               off_o
);

  // Scan from the top down so the lowest matching window is taken last.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '1;
    off_o = '0;
    for (int k = NUM_BARS - 1; k >= 0; k--) begin
      if (match_i[k]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(k);
        off_o = offs_i[k];
      end
    end
  end

endmodule

// File: rtl/bar_decoder.sv
module bar_decoder #(
  parameter int NUM_BARS = 6,
  parameter int ADDR_W   = 32,
  parameter int CFG_W    = 8,
  parameter int BAR0_OFF = 16,
  parameter int IO_LOW   = 2,
  parameter int MEM_LOW  = 4,
  parameter logic [NUM_BARS-1:0][ADDR_W-1:0] BAR_SIZE = {
    32'h1000_0000, 32'h0000_0020, 32'h0000_0000,
    32'h0001_0000, 32'h0000_0100, 32'h0000_1000
  }
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_wr_en,
  input  logic [CFG_W-1:0]              cfg_off,
  input  logic [ADDR_W-1:0]             cfg_wdata,
  input  logic [ADDR_W-1:0]             lookup_addr,
  output logic                          hit,
  output logic [$clog2(NUM_BARS+1)-1:0] hit_idx,
  output logic [ADDR_W-1:0]             hit_off,
  output logic [NUM_BARS-1:0]           bar_is_io
);

  localparam int IDX_W = $clog2(NUM_BARS + 1);

  logic [NUM_BARS-1:0][ADDR_W-1:0] win_base;
  logic [NUM_BARS-1:0][ADDR_W-1:0] win_off;
  logic [NUM_BARS-1:0]             win_match;

  bar_cfg_regs #(
    .NUM_BARS(NUM_BARS), .ADDR_W(ADDR_W), .CFG_W(CFG_W),
    .BAR0_OFF(BAR0_OFF), .IO_LOW(IO_LOW), .MEM_LOW(MEM_LOW)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_off(cfg_off),
    .wr_data(cfg_wdata), .base_o(win_base), .io_o(bar_is_io)
  );

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_win
    bar_window #(.ADDR_W(ADDR_W), .SIZE(BAR_SIZE[i])) u_win (
      .base_i(win_base[i]), .addr_i(lookup_addr),
      .match_o(win_match[i]), .offset_o(win_off[i])
    );
  end

  bar_prio_sel #(.NUM_BARS(NUM_BARS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_sel (
    .match_i(win_match), .offs_i(win_off),
    .hit_o(hit), .idx_o(hit_idx), .off_o(hit_off)
  );

  AST_MISS_REPORTS_NONE: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (hit_idx == '1) && (hit_off == '0)); // R4

  AST_HIT_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    hit |-> (hit_idx < IDX_W'(NUM_BARS))); // R1

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
    hit |-> ((win_match & ((NUM_BARS'(1) << hit_idx) - NUM_BARS'(1))) == '0)); // R2

  AST_HIT_HAS_MATCH: assert property (@(posedge clk) disable iff (rst)
    hit |-> (win_match != '0)); // R1

endmodule

// File: tb/tb_bar_decoder.sv
module tb_bar_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_off = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] lookup_addr = '0;
  logic        hit;
  logic [2:0]  hit_idx;
  logic [31:0] hit_off;
  logic [5:0]  bar_is_io;

  bar_decoder dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .lookup_addr(lookup_addr), .hit(hit),
    .hit_idx(hit_idx), .hit_off(hit_off), .bar_is_io(bar_is_io)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;

  // Window sizes from the requirement defaults: 0x1000, 0x100, 0x10000, 0, 0x20, 0x10000000.
  logic [31:0] sz [6];
  logic [31:0] mb [6];
  logic        mio [6];

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic void model_reset();
    for (int k = 0; k < 6; k++) begin
      mb[k]  = '0;
      mio[k] = 1'b0;
    end
  endfunction

  function automatic void model_write(input logic [7:0] off, input logic [31:0] d);
    int k;
    if (off >= 8'h10 && off <= 8'h27) begin
      k = (int'(off) - 16) / 4;
      mio[k] = d[0];
      mb[k]  = d[0] ? (d & 32'hFFFF_FFFC) : (d & 32'hFFFF_FFF0);
    end
  endfunction

  function automatic void model_decode(input logic [31:0] a, output logic h,
                                       output logic [2:0] i, output logic [31:0] o);
    h = 1'b0;
    i = 3'b111;
    o = '0;
    for (int k = 5; k >= 0; k--) begin
      if (sz[k] != 0 && {1'b0, a} >= {1'b0, mb[k]} &&
          {1'b0, a} < ({1'b0, mb[k]} + {1'b0, sz[k]})) begin
        h = 1'b1;
        i = 3'(k);
        o = a - mb[k];
      end
    end
  endfunction

  task automatic probe(input logic [31:0] a, input string req);
    logic h;
    logic [2:0] i;
    logic [31:0] o;
    lookup_addr = a;
    #1;
    model_decode(a, h, i, o);
    total++;
    if (hit !== h || hit_idx !== i || hit_off !== o) begin
      bad++;
      $display("FAIL %s addr=%h actual hit=%b idx=%0d off=%h expected hit=%b idx=%0d off=%h",
               req, a, hit, hit_idx, hit_off, h, i, o);
    end
  endtask

  task automatic check_types(input string req);
    logic [5:0] e;
    for (int k = 0; k < 6; k++) e[k] = mio[k];
    total++;
    if (bar_is_io !== e) begin
      bad++;
      $display("FAIL %s bar_is_io actual=%b expected=%b", req, bar_is_io, e);
    end
  endtask

  task automatic cfg_write(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_off   = off;
    cfg_wdata = d;
    @(posedge clk);
    model_write(off, d);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic probe_edges(input int k, input string req);
    probe(mb[k] - 1, req);
    probe(mb[k], req);
    probe(mb[k] + sz[k] - 1, req);
    probe(mb[k] + sz[k], req);
  endtask

  initial begin
    logic [31:0] r;
    sz[0] = 32'h0000_1000; sz[1] = 32'h0000_0100; sz[2] = 32'h0001_0000;
    sz[3] = 32'h0000_0000; sz[4] = 32'h0000_0020; sz[5] = 32'h1000_0000;
    model_reset();
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R8: reset state, every base 0, memory type
    check_types("R8");
    probe(32'h0, "R8");
    probe(32'h0000_0FFF, "R1");
    probe(32'h0000_1000, "R1");
    probe(32'h0001_0000, "R1");
    probe(32'h1000_0000, "R4");

    // R6: I/O write clears two low bits, memory write clears four
    cfg_write(8'h10, 32'h0004_000B);
    check_types("R6");
    probe(32'h0004_0008, "R6");
    probe(32'h0004_0007, "R6");
    cfg_write(8'h18, 32'h0300_00FF);
    check_types("R6");
    probe_edges(2, "R6");

    // R2: overlapping windows, lowest index wins
    cfg_write(8'h14, 32'h0004_0000);
    probe(32'h0004_0010, "R2");
    probe(32'h0004_0000, "R2");
    probe_edges(1, "R2");

    // R3: offsets inside windows
    cfg_write(8'h20, 32'h0500_0040);
    probe(32'h0500_0055, "R3");
    probe_edges(4, "R3");

    // R7: offsets just outside the block are ignored; unaligned offsets map by word
    cfg_write(8'h0C, 32'h7777_0000);
    cfg_write(8'h28, 32'h7777_0000);
    probe(32'h0004_0008, "R7");
    probe(32'h0500_0040, "R7");
    check_types("R7");
    cfg_write(8'h26, 32'hF000_0000);
    check_types("R7");

    // R9: window ending at 2^32
    probe(32'hFFFF_FFFF, "R9");
    probe(32'hF000_0000, "R9");
    probe(32'hEFFF_FFFF, "R9");

    // R5: zero-size window never hits
    cfg_write(8'h1C, 32'h8000_0000);
    probe(32'h8000_0000, "R5");
    probe(32'h8000_0004, "R5");

    // R10: write is not visible before its clock edge
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_off   = 8'h10;
    cfg_wdata = 32'h0900_0000;
    probe(32'h0900_0000, "R10");
    @(posedge clk);
    model_write(8'h10, 32'h0900_0000);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    probe(32'h0900_0000, "R10");

    // R4: far miss
    probe(32'hA000_0000, "R4");

    // Random mix of writes and probes
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(3) == 0) begin
        r = $urandom;
        if ($urandom_range(1) == 0) r = r & 32'h0FFF_FFFF;
        cfg_write(8'($urandom_range(8'h08, 8'h2B)), r);
        check_types("R6");
      end
      for (int p = 0; p < 4; p++) begin
        int k;
        k = $urandom_range(5);
        case ($urandom_range(3))
          0: probe($urandom, "R1");
          1: probe(mb[k] + $urandom_range(sz[k] == 0 ? 0 : 32'(sz[k] - 1)), "R3");
          2: probe(mb[k] + sz[k] - 32'($urandom_range(2)), "R1");
          default: probe(mb[k] - 32'($urandom_range(2)), "R2");
        endcase
      end
    end

    // R8: reset mid-run restores the reset state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    check_types("R8");
    probe(32'h0, "R8");
    probe(32'h0000_2000, "R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule